// File: doc/BRIEF.md
# Three-Wire Control Register Interface for an Optical Front End

This block is the digital control port of an optical sensing front end. An external controller drives three pins: a serial clock, an active-low select and one bidirectional data line. The controller uses them to program a five-entry register file. All three pins are brought into the system clock domain through two-flop synchronisers, and the edges are found there. The system clock must run at least eight times faster than the serial clock.

Every transfer is a ten-bit frame, sent most significant bit first. Its two leading bits are a header. Writes are indirect: an address frame picks the target entry, and any number of later data frames store bytes into it. A read frame turns the data line around and streams out all five entries in ascending index order. The register fields drive the analog side directly: a transimpedance range, an amplifier gain, two comparator thresholds and a control byte.

The block also decodes two things from idle pin levels. A standby request is raised when the serial clock and select are both held high, or when the control byte asks for it. Between frames, the level of the data line picks which threshold entry feeds the comparator.

Top module: `afe_serial_regs`

## Requirements
- R1: After reset the entries read 0xFF, except entry 4, which reads 0xBF. The outputs then show gain 0xFF, range 2, GFA 3, comparator disable 1, standby 0 and the data-line driver off.
- R2: A frame is accepted when select rises after exactly 10 serial clock rises. The bits are MSB first, with the header in bits 9:8. Header 00 loads the address register from bits 3:0.
- R3: Header 01 stores bits 7:0 into the currently addressed entry. The address stays in place, so repeated data frames keep hitting the same entry.
- R4: After the header bits 1 then 0 are received, the data-line driver turns on at the second serial clock rise. It then launches 40 bits on serial clock rises: entries 0,1,2,3,4 in turn, each MSB first. The driver is off before the second rise.
- R5: The data-line driver turns off on the select rise that ends a read.
- R6: A frame with header 11 changes nothing. A data frame is ignored while the address is above 4. A frame whose bit count is not 10 is ignored.
- R7: The range output is entry 0 bits 1:0, except that code 3 maps to 2.
- R8: The threshold select output is 1 when the data line is idle high and 0 when it is idle low. The threshold code output is bits 4:0 of entry 2 or entry 3 respectively. While select is low, the select output keeps the value it had before select fell.
- R9: Standby is 1 when entry 4 bit 6 is 1, or when select and serial clock are both high. Frames are still accepted after the pins leave that state.
- R10: The comparator disable output is entry 4 bit 7. The GFA output is entry 4 bits 1:0. The gain output is entry 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | Serial clock pin |
| csn_i | input | 1 | Active-low frame select pin |
| dio_i | input | 1 | Data line as seen at the pad |
| dio_o | output | 1 | Read data launched onto the data line |
| dio_oe_o | output | 1 | Data-line output enable |
| ti_range_o | output | 2 | Decoded transimpedance range (0, 1 or 2) |
| gain_code_o | output | 8 | Amplifier gain code |
| thr_sel_o | output | 1 | 1 selects threshold entry 2, 0 selects entry 3 |
| thr_code_o | output | 5 | Selected comparator threshold code |
| gfa_o | output | 2 | Amplifier bandwidth code |
| comp_dis_o | output | 1 | Comparator output disable |
| standby_o | output | 1 | Analog standby request |

## Verification
The bench models the register file itself and drives it through the pins only. It writes many values into every entry and reads the whole file back through the turned-around data line. A design with a wrong shift direction, a wrong entry order or an off-by-one launch edge returns rotated or shifted bytes. Frames with 9 or 11 bits, header 11 and out-of-range addresses are sent to catch decoders that count bits loosely or wrap the address onto a real entry. Such a design would corrupt an entry. Range code 3 is swept to catch a decoder that passes it through. The data line is toggled in the middle of a frame, so a design that lets the threshold selection follow the line during a transfer is caught.

// File: rtl/afe_serial_pkg.sv
package afe_serial_pkg;

  localparam int FRAME_BITS = 10;
  localparam int DATA_BITS  = 8;
  localparam int NUM_REGS   = 5;
  localparam int ADDR_BITS  = 4;
  localparam int THR_BITS   = 5;
  localparam int SNAP_BITS  = NUM_REGS * DATA_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  localparam int IDX_RANGE = 0;
  localparam int IDX_GAIN  = 1;
  localparam int IDX_THR_A = 2;
  localparam int IDX_THR_B = 3;
  localparam int IDX_CTRL  = 4;

  typedef enum logic [1:0] {
    HDR_ADDR = 2'b00,
    HDR_DATA = 2'b01,
    HDR_READ = 2'b10,
    HDR_NONE = 2'b11
  } hdr_e;

  function automatic logic [DATA_BITS-1:0] reset_value(input int idx);
    return (idx == IDX_CTRL) ? 8'hBF : 8'hFF;
  endfunction

  function automatic logic [1:0] range_decode(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction

endpackage

// File: rtl/afe_pin_sync.sv
module afe_pin_sync #(
  parameter int           N       = 3,
  parameter int           STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);

  for (genvar g = 0; g < N; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        chain_q <= {STAGES{RST_VAL[g]}};
        prev_q  <= RST_VAL[g];
      end else begin
        chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
        prev_q  <= chain_q[STAGES-1];
      end
    end

    assign lvl_o[g]  = chain_q[STAGES-1];
    assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
    assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
  end

endmodule

// File: rtl/afe_frame_engine.sv
module afe_frame_engine
  import afe_serial_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sclk_rise_i,
  input  logic                 csn_lvl_i,
  input  logic                 csn_rise_i,
  input  logic                 csn_fall_i,
  input  logic                 dio_lvl_i,
  input  logic [SNAP_BITS-1:0] snap_i,
  output logic                 frame_ok_o,
  output hdr_e                 hdr_o,
  output logic [DATA_BITS-1:0] payload_o,
  output logic                 dout_o,
  output logic                 doe_o
);

  logic [FRAME_BITS-1:0] shreg_q;
  logic [CNT_W-1:0]      cnt_q;
  logic                  rd_active_q;
  logic [SNAP_BITS-1:0]  rd_buf_q;
  logic                  bit_take_w;
  logic                  read_start_w;

  assign bit_take_w   = sclk_rise_i & ~csn_lvl_i;
  assign read_start_w = bit_take_w & ~rd_active_q & (cnt_q == CNT_W'(1))
                        & shreg_q[0] & ~dio_lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q     <= '0;
      cnt_q       <= '0;
      rd_active_q <= 1'b0;
      rd_buf_q    <= '0;
    end else begin
      if (csn_fall_i) begin
        shreg_q     <= '0;
        cnt_q       <= '0;
        rd_active_q <= 1'b0;
      end else if (bit_take_w) begin
        shreg_q <= {shreg_q[FRAME_BITS-2:0], dio_lvl_i};
        if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
        if (rd_active_q) begin
          rd_buf_q <= {rd_buf_q[SNAP_BITS-2:0], 1'b0};
        end else if (read_start_w) begin
          rd_active_q <= 1'b1;
          rd_buf_q    <= snap_i;
        end
      end
      if (csn_rise_i) rd_active_q <= 1'b0;
    end
  end

  assign frame_ok_o = csn_rise_i & (cnt_q == CNT_W'(FRAME_BITS));
  assign hdr_o      = hdr_e'(shreg_q[FRAME_BITS-1 -: 2]);
  assign payload_o  = shreg_q[DATA_BITS-1:0];
  assign dout_o     = rd_buf_q[SNAP_BITS-1];
  assign doe_o      = rd_active_q;

  AST_OE_DROPS_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_rise_i |=> !doe_o); // R5
  AST_OE_OFF_AT_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csn_fall_i |=> !doe_o); // R4
  AST_OE_INSIDE_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    doe_o |-> (!csn_lvl_i || csn_rise_i)); // R5

endmodule

// File: rtl/afe_reg_bank.sv
module afe_reg_bank
  import afe_serial_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_ok_i,
  input  hdr_e                 hdr_i,
  input  logic [DATA_BITS-1:0] payload_i,
  output logic [SNAP_BITS-1:0] snap_o
);

  logic [ADDR_BITS-1:0] addr_q;
  logic [NUM_REGS-1:0]  wr_hit_w;
  logic                 data_frame_w;

  assign data_frame_w = frame_ok_i & (hdr_i == HDR_DATA);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) addr_q <= '0;
    else if (frame_ok_i && hdr_i == HDR_ADDR) addr_q <= payload_i[ADDR_BITS-1:0];
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_BITS-1:0] val_q;
    assign wr_hit_w[i] = data_frame_w & (addr_q == ADDR_BITS'(i));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          val_q <= reset_value(i);
      else if (wr_hit_w[i]) val_q <= payload_i;
    end
    assign snap_o[(NUM_REGS-1-i)*DATA_BITS +: DATA_BITS] = val_q;
  end

  AST_ONE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_hit_w)); // R3
  AST_HOLD_WITHOUT_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_frame_w |=> $stable(snap_o)); // R3
  AST_BAD_ADDR_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_frame_w && addr_q >= ADDR_BITS'(NUM_REGS)) |=> $stable(snap_o)); // R6

endmodule

// File: rtl/afe_serial_regs.sv
module afe_serial_regs
  import afe_serial_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       csn_i,
  input  logic       dio_i,
  output logic       dio_o,
  output logic       dio_oe_o,
  output logic [1:0] ti_range_o,
  output logic [7:0] gain_code_o,
  output logic       thr_sel_o,
  output logic [4:0] thr_code_o,
  output logic [1:0] gfa_o,
  output logic       comp_dis_o,
  output logic       standby_o
);

  localparam int PIN_SCLK = 0;
  localparam int PIN_CSN  = 1;
  localparam int PIN_DIO  = 2;

  logic [2:0] lvl_w, rise_w, fall_w;
  logic                 frame_ok_w;
  hdr_e                 hdr_w;
  logic [DATA_BITS-1:0] payload_w;
  logic [SNAP_BITS-1:0] snap_w;
  logic                 thr_sel_q;

  afe_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({dio_i, csn_i, sclk_i}),
    .lvl_o  (lvl_w),
    .rise_o (rise_w),
    .fall_o (fall_w)
  );

  afe_frame_engine u_frame (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sclk_rise_i (rise_w[PIN_SCLK]),
    .csn_lvl_i   (lvl_w[PIN_CSN]),
    .csn_rise_i  (rise_w[PIN_CSN]),
    .csn_fall_i  (fall_w[PIN_CSN]),
    .dio_lvl_i   (lvl_w[PIN_DIO]),
    .snap_i      (snap_w),
    .frame_ok_o  (frame_ok_w),
    .hdr_o       (hdr_w),
    .payload_o   (payload_w),
    .dout_o      (dio_o),
    .doe_o       (dio_oe_o)
  );

  afe_reg_bank u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_ok_i (frame_ok_w),
    .hdr_i      (hdr_w),
    .payload_i  (payload_w),
    .snap_o     (snap_w)
  );

  function automatic logic [DATA_BITS-1:0] entry(input logic [SNAP_BITS-1:0] s, input int idx);
    return s[(NUM_REGS-1-idx)*DATA_BITS +: DATA_BITS];
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             thr_sel_q <= 1'b1;
    else if (lvl_w[PIN_CSN]) thr_sel_q <= lvl_w[PIN_DIO];
  end

  logic [DATA_BITS-1:0] ctrl_w;
  assign ctrl_w      = entry(snap_w, IDX_CTRL);
  assign ti_range_o  = range_decode(entry(snap_w, IDX_RANGE)[1:0]);
  assign gain_code_o = entry(snap_w, IDX_GAIN);
  assign thr_sel_o   = thr_sel_q;
  assign thr_code_o  = thr_sel_q ? entry(snap_w, IDX_THR_A)[THR_BITS-1:0]
                                 : entry(snap_w, IDX_THR_B)[THR_BITS-1:0];
  assign gfa_o       = ctrl_w[1:0];
  assign comp_dis_o  = ctrl_w[7];
  assign standby_o   = ctrl_w[6] | (lvl_w[PIN_CSN] & lvl_w[PIN_SCLK]);

  AST_THR_HELD_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!lvl_w[PIN_CSN] && $past(!lvl_w[PIN_CSN])) |-> $stable(thr_sel_o)); // R8
  AST_RANGE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ti_range_o != 2'd3); // R7

endmodule

// File: tb/afe_serial_regs_test.sv
`timescale 1ns/1ps
module afe_serial_regs_test;

  localparam int H = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, drv = 1'b1, idle_dio = 1'b1;
  logic dout, doe, thr_sel, comp_dis, standby;
  logic [1:0] ti_range, gfa;
  logic [7:0] gain;
  logic [4:0] thr_code;
  logic dio_line;
  logic [7:0] m [5];
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  assign dio_line = doe ? dout : drv;

  afe_serial_regs uut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .csn_i(csn), .dio_i(dio_line),
    .dio_o(dout), .dio_oe_o(doe), .ti_range_o(ti_range), .gain_code_o(gain),
    .thr_sel_o(thr_sel), .thr_code_o(thr_code), .gfa_o(gfa),
    .comp_dis_o(comp_dis), .standby_o(standby)
  );

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input logic [15:0] bits, input int n);
    sclk = 1'b0;
    csn = 1'b0;
    wt(H);
    for (int i = 0; i < n; i++) begin
      drv = bits[n-1-i];
      wt(H); sclk = 1'b1; wt(H); sclk = 1'b0;
    end
    wt(H);
    csn = 1'b1;
    drv = idle_dio;
    wt(3*H);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    send_bits({6'd0, 2'b00, a}, 10);
    send_bits({6'd0, 2'b01, d}, 10);
    if (a < 8'd5) m[a] = d;
  endtask

  task automatic read_check(input string req);
    logic [39:0] got, exp;
    logic oe_ok, early_off;
    oe_ok = 1'b1; early_off = 1'b1; got = '0;
    sclk = 1'b0; csn = 1'b0;
    wt(H);
    for (int k = 0; k <= 40; k++) begin
      if (k < 2) drv = (k == 0);
      wt(H); sclk = 1'b1; wt(H);
      if (k == 0) early_off = !doe;
      else begin
        got[40-k] = dio_line;
        if (!doe) oe_ok = 1'b0;
      end
      sclk = 1'b0;
    end
    wt(H);
    csn = 1'b1;
    drv = idle_dio;
    wt(3*H);
    exp = {m[0], m[1], m[2], m[3], m[4]};
    chk(early_off, "R4 driver off before second header bit", 64'(!early_off), 0);
    chk(oe_ok, "R4 driver on through read", 64'(oe_ok), 1);
    chk(got == exp, req, 64'(got), 64'(exp));
    chk(!doe, "R5 driver off after select rise", 64'(doe), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 5; i++) m[i] = (i == 4) ? 8'hBF : 8'hFF;
    wt(5);
    rst_n = 1'b1;
    wt(10);

    // R1 reset state
    chk(gain == 8'hFF, "R1 gain", gain, 8'hFF);
    chk(ti_range == 2'd2, "R1 range", ti_range, 2);
    chk(gfa == 2'd3, "R1 gfa", gfa, 3);
    chk(comp_dis == 1'b1, "R1 comp_dis", comp_dis, 1);
    chk(standby == 1'b0, "R1 standby", standby, 0);
    chk(doe == 1'b0, "R1 driver off", doe, 0);
    chk(thr_sel && thr_code == 5'h1F, "R1 threshold", {thr_sel, thr_code}, {1'b1, 5'h1F});
    read_check("R1 reset readback");

    // R2 R3 address then sticky data
    wr(8'd1, 8'h5A);
    chk(gain == 8'h5A, "R2 R3 gain write", gain, 8'h5A);
    send_bits({6'd0, 2'b01, 8'hC3}, 10); m[1] = 8'hC3;
    chk(gain == 8'hC3, "R3 repeated data frame", gain, 8'hC3);
    for (int v = 0; v < 256; v += 17) begin
      send_bits({6'd0, 2'b01, 8'(v)}, 10); m[1] = 8'(v);
      chk(gain == 8'(v), "R10 gain sweep", gain, v);
    end

    // R7 range decode
    for (int c = 0; c < 4; c++) begin
      wr(8'd0, {6'b101010, 2'(c)});
      chk(ti_range == ((c == 3) ? 2'd2 : 2'(c)), "R7 range decode", ti_range, (c == 3) ? 2 : c);
    end

    // R8 threshold selection
    wr(8'd2, 8'h0A);
    wr(8'd3, 8'h15);
    chk(thr_sel == 1'b1 && thr_code == 5'h0A, "R8 idle high", {thr_sel, thr_code}, {1'b1, 5'h0A});
    idle_dio = 1'b0; drv = 1'b0; wt(4*H);
    chk(thr_sel == 1'b0 && thr_code == 5'h15, "R8 idle low", {thr_sel, thr_code}, {1'b0, 5'h15});
    idle_dio = 1'b1; drv = 1'b1; wt(4*H);
    csn = 1'b0; wt(H); drv = 1'b0; wt(6*H);
    chk(thr_sel == 1'b1 && thr_code == 5'h0A, "R8 held in frame", {thr_sel, thr_code}, {1'b1, 5'h0A});
    drv = 1'b1; wt(H); drv = 1'b0; wt(H);
    csn = 1'b1; drv = 1'b1; wt(4*H);
    chk(thr_sel == 1'b1, "R8 idle high after frame", thr_sel, 1);

    // R9 R10 control entry
    wr(8'd4, 8'h81);
    chk(comp_dis == 1'b1 && gfa == 2'd1 && standby == 1'b0, "R10 ctrl 81",
        {comp_dis, gfa, standby}, {1'b1, 2'd1, 1'b0});
    wr(8'd4, 8'h42);
    chk(comp_dis == 1'b0 && gfa == 2'd2 && standby == 1'b1, "R9 R10 ctrl 42",
        {comp_dis, gfa, standby}, {1'b0, 2'd2, 1'b1});
    wr(8'd4, 8'h03);
    chk(standby == 1'b0 && gfa == 2'd3, "R9 ctrl standby off", {standby, gfa}, {1'b0, 2'd3});

    // R9 pin standby and serial still working
    sclk = 1'b1; wt(4*H);
    chk(standby == 1'b1, "R9 pin standby", standby, 1);
    wr(8'd1, 8'h33);
    chk(standby == 1'b0, "R9 standby released", standby, 0);
    chk(gain == 8'h33, "R9 write after standby", gain, 8'h33);

    // R6 ignored frames
    send_bits({6'd0, 2'b11, 8'h00}, 10);
    send_bits({6'd0, 2'b00, 8'h01}, 10);
    send_bits({7'd0, 2'b01, 7'h00}, 9);
    chk(gain == 8'h33, "R6 nine-bit frame", gain, 8'h33);
    send_bits({5'd0, 2'b01, 8'h00, 1'b0}, 11);
    chk(gain == 8'h33, "R6 eleven-bit frame", gain, 8'h33);
    wr(8'd7, 8'h00);
    wr(8'd5, 8'h11);
    read_check("R6 ignored frames readback");

    // R4 readback with distinct values
    wr(8'd0, 8'h96); wr(8'd1, 8'hE1); wr(8'd2, 8'h3C); wr(8'd3, 8'h78); wr(8'd4, 8'h05);
    chk(ti_range == 2'd2 && thr_code == 5'h1C, "R7 R8 final fields", {ti_range, thr_code}, {2'd2, 5'h1C});
    read_check("R4 full readback");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule